// File: doc/BRIEF.md
# EPP 1.9 Host Cycle Engine

This block is the host-side sequencer for Enhanced Parallel Port address and data transfers. A host issues a one-cycle read or write request together with a register select (address or data) and, for writes, a byte. The engine then runs the interlocked handshake with the peripheral. It drives the write-direction line, one of the two strobes and the output enable of the bidirectional data bus, and it samples the peripheral's wait line. While a transfer is in progress the host ready output is held low. Ready returns high once the peripheral lets the transfer finish.

The wait line passes through a synchronizer before the engine acts on it. No strobe or direction change is made while the synchronized wait line is high. A watchdog bounds each transfer. If the peripheral stalls beyond the limit, the strobe is dropped, ready is released and a sticky timeout flag is raised. The host clears that flag with a clear pulse.

Two control inputs alter the transfer. With the strobe-override bit set, the bus is driven and the write line is asserted even on a read. With the input-direction bit set, a requested write becomes a read on the bus and no error is raised.

Top module: `epp_cycle_engine`

## Requirements
- R1: After reset, hst_ready is 1, pp_nwrite, pp_ndstb and pp_nastb are 1, pp_doe is 0 and sts_timeout is 0.
- R2: On the clock edge that accepts a request (hst_rd or hst_wr high while hst_ready is 1), hst_ready goes low. It stays low until the transfer ends.
- R3: If the synchronized pp_nwait is high when a transfer starts, the strobes, pp_nwrite, pp_doe and pp_dout are left unchanged until pp_nwait is seen low.
- R4: In a write, the strobe asserts (goes low) with pp_nwrite=0, pp_doe=1 and pp_dout equal to the request byte. hst_sel_addr=1 selects pp_nastb and 0 selects pp_ndstb. At most one strobe is low at any time.
- R5: An asserted strobe stays low while pp_nwait is low. Once pp_nwait is seen high, the strobe goes high on the same edge at which hst_ready returns to 1.
- R6: In a read, the strobe asserts with pp_nwrite=1 and pp_doe=0. hst_rdata then holds the value of pp_din sampled while pp_nwait was high.
- R7: If a transfer has not completed TIMEOUT_US microseconds (CLK_KHZ*TIMEOUT_US/1000 cycles) after acceptance, it is aborted. The strobe goes high, hst_ready returns to 1 and sts_timeout is set.
- R8: sts_timeout stays 1 until sts_clr is pulsed. A timeout in the same cycle as a clear takes precedence.
- R9: With ctl_strobe_ovr=1 when a transfer is requested, the transfer runs with pp_nwrite=0 and pp_doe=1, even for a read.
- R10: With ctl_dir_in=1, a write request produces a read transfer (pp_nwrite=1, pp_doe=0, pp_dout unchanged, hst_rdata captured). sts_timeout is not set.
- R11: pp_nwrite, pp_doe and pp_dout hold their values after a transfer ends. They change for the next transfer only once pp_nwait is seen low, and stay stable while a strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_rd | input | 1 | Read request pulse |
| hst_wr | input | 1 | Write request pulse |
| hst_sel_addr | input | 1 | 1 selects the address register, 0 the data register |
| hst_wdata | input | DW | Write byte |
| hst_rdata | output | DW | Last byte read from the bus |
| hst_ready | output | 1 | High when no transfer is in progress |
| ctl_strobe_ovr | input | 1 | Force bus drive and write line for the transfer |
| ctl_dir_in | input | 1 | Bus direction is input; writes become reads |
| sts_timeout | output | 1 | Sticky watchdog abort flag |
| sts_clr | input | 1 | Clears sts_timeout |
| pp_nwait | input | 1 | Peripheral wait line, asynchronous |
| pp_nwrite | output | 1 | Write direction line, active low |
| pp_ndstb | output | 1 | Data strobe, active low |
| pp_nastb | output | 1 | Address strobe, active low |
| pp_dout | output | DW | Bus output byte |
| pp_doe | output | 1 | Bus output enable |
| pp_din | input | DW | Bus input byte |

## Verification
The bench builds the engine with CLK_KHZ=4000 and TIMEOUT_US=10, which makes the watchdog limit 40 cycles. At that size the abort can be measured to the exact cycle, alongside stalls of 20 cycles that must not abort. The synchronizer keeps its default depth of two, so the test covers the latency from a wait-line change to the strobe or ready response.

// File: rtl/epp_cycle_engine.sv
module epp_cycle_engine #(
  parameter int CLK_KHZ     = 125000,
  parameter int TIMEOUT_US  = 10,
  parameter int SYNC_STAGES = 2,
  parameter int DW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hst_rd,
  input  logic          hst_wr,
  input  logic          hst_sel_addr,
  input  logic [DW-1:0] hst_wdata,
  output logic [DW-1:0] hst_rdata,
  output logic          hst_ready,
  input  logic          ctl_strobe_ovr,
  input  logic          ctl_dir_in,
  output logic          sts_timeout,
  input  logic          sts_clr,
  input  logic          pp_nwait,
  output logic          pp_nwrite,
  output logic          pp_ndstb,
  output logic          pp_nastb,
  output logic [DW-1:0] pp_dout,
  output logic          pp_doe,
  input  logic [DW-1:0] pp_din
);

  localparam int TO_CYC = CLK_KHZ * TIMEOUT_US / 1000;
  localparam int CW     = $clog2(TO_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_STB} st_t;

  st_t                    st;
  logic [CW-1:0]          wd_cnt;
  logic [SYNC_STAGES-1:0] sync;
  logic                   nwait_s;
  logic                   op_drive, op_load, op_addr;
  logic [DW-1:0]          wbuf;
  logic                   req, wd_hit, done, abort;

  assign nwait_s   = sync[SYNC_STAGES-1];
  assign req       = hst_rd | hst_wr;
  assign wd_hit    = (wd_cnt == CW'(TO_CYC - 1));
  assign done      = (st == S_STB) && nwait_s;
  assign abort     = (((st == S_PRE)) || ((st == S_STB) && !nwait_s)) && wd_hit;
  assign hst_ready = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '1;
    else        sync <= {sync[SYNC_STAGES-2:0], pp_nwait};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_timeout <= 1'b0;
    else        sts_timeout <= abort | (sts_timeout & ~sts_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      wd_cnt    <= '0;
      op_drive  <= 1'b0;
      op_load   <= 1'b0;
      op_addr   <= 1'b0;
      wbuf      <= '0;
      hst_rdata <= '0;
      pp_nwrite <= 1'b1;
      pp_ndstb  <= 1'b1;
      pp_nastb  <= 1'b1;
      pp_dout   <= '0;
      pp_doe    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          st       <= S_PRE;
          wd_cnt   <= '0;
          op_load  <= hst_wr & ~ctl_dir_in;
          op_drive <= (hst_wr & ~ctl_dir_in) | ctl_strobe_ovr;
          op_addr  <= hst_sel_addr;
          wbuf     <= hst_wdata;
        end
        S_PRE: begin
          if (abort) begin
            st <= S_IDLE;
          end else begin
            wd_cnt <= wd_cnt + 1'b1;
            if (!nwait_s) begin
              st        <= S_STB;
              pp_nwrite <= ~op_drive;
              pp_doe    <= op_drive;
              if (op_load) pp_dout <= wbuf;
              pp_ndstb  <= op_addr;
              pp_nastb  <= ~op_addr;
            end
          end
        end
        S_STB: begin
          if (done) begin
            hst_rdata <= pp_din;
            pp_ndstb  <= 1'b1;
            pp_nastb  <= 1'b1;
            st        <= S_IDLE;
          end else if (abort) begin
            pp_ndstb  <= 1'b1;
            pp_nastb  <= 1'b1;
            st        <= S_IDLE;
          end else begin
            wd_cnt <= wd_cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module epp_cycle_chk #(parameter int DW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic          hst_ready,
  input logic          pp_ndstb,
  input logic          pp_nastb,
  input logic          pp_nwrite,
  input logic [DW-1:0] pp_dout,
  input logic          pp_doe,
  input logic          sts_timeout,
  input logic          sts_clr,
  input logic          nwait_s
);
  logic stb_on;
  assign stb_on = !pp_ndstb || !pp_nastb;

  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!pp_ndstb, !pp_nastb}));

  // R2
  busy_while_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_on |-> !hst_ready);

  // R3
  strobe_needs_wait_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pp_ndstb) || $fell(pp_nastb)) |-> $past(!nwait_s));

  // R5
  release_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pp_ndstb) || $rose(pp_nastb)) |-> hst_ready);

  // R7
  timeout_ends_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_timeout) |-> (hst_ready && !stb_on));

  // R8
  timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_timeout && !sts_clr) |=> sts_timeout);

  // R11
  bus_stable_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_on && $past(stb_on)) |-> ($stable(pp_nwrite) && $stable(pp_doe) && $stable(pp_dout)));
endmodule

bind epp_cycle_engine epp_cycle_chk #(.DW(DW)) chk (
  .clk(clk), .rst_n(rst_n), .hst_ready(hst_ready), .pp_ndstb(pp_ndstb),
  .pp_nastb(pp_nastb), .pp_nwrite(pp_nwrite), .pp_dout(pp_dout), .pp_doe(pp_doe),
  .sts_timeout(sts_timeout), .sts_clr(sts_clr), .nwait_s(nwait_s)
);

// File: tb/tb_epp_cycle_engine.sv
`timescale 1ns/1ps
module tb_epp_cycle_engine;
  localparam int DW = 8;
  localparam int TO = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hst_rd = 0, hst_wr = 0, hst_sel_addr = 0, ctl_strobe_ovr = 0, ctl_dir_in = 0, sts_clr = 0;
  logic [DW-1:0] hst_wdata = '0, pp_din = '0;
  logic pp_nwait = 1'b0;
  logic [DW-1:0] hst_rdata, pp_dout;
  logic hst_ready, sts_timeout, pp_nwrite, pp_ndstb, pp_nastb, pp_doe;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  epp_cycle_engine #(.CLK_KHZ(4000), .TIMEOUT_US(10), .SYNC_STAGES(2), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .hst_rd(hst_rd), .hst_wr(hst_wr), .hst_sel_addr(hst_sel_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_ready(hst_ready),
    .ctl_strobe_ovr(ctl_strobe_ovr), .ctl_dir_in(ctl_dir_in), .sts_timeout(sts_timeout),
    .sts_clr(sts_clr), .pp_nwait(pp_nwait), .pp_nwrite(pp_nwrite), .pp_ndstb(pp_ndstb),
    .pp_nastb(pp_nastb), .pp_dout(pp_dout), .pp_doe(pp_doe), .pp_din(pp_din));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic request(input bit wr, input bit addr, input logic [DW-1:0] d);
    @(negedge clk);
    hst_wr = wr; hst_rd = !wr; hst_sel_addr = addr; hst_wdata = d;
    @(negedge clk);
    hst_wr = 0; hst_rd = 0;
  endtask

  task automatic wait_strobe(output bit seen);
    seen = 0;
    for (int i = 0; i < 10 && !seen; i++) begin
      if (!pp_ndstb || !pp_nastb) seen = 1; else @(negedge clk);
    end
  endtask

  task automatic finish_cycle(input string tag);
    bit rdy = 0;
    pp_nwait = 1;
    for (int i = 0; i < 8 && !rdy; i++) begin
      @(negedge clk);
      if (hst_ready) rdy = 1;
    end
    chk(rdy && pp_ndstb && pp_nastb, tag, {rdy, pp_ndstb, pp_nastb}, 3'b111);
    pp_nwait = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_write(input bit addr, input logic [DW-1:0] d);
    bit seen;
    request(1, addr, d);
    chk(hst_ready == 0, "R2 ready low", hst_ready, 0);
    wait_strobe(seen);
    chk(seen && (addr ? !pp_nastb && pp_ndstb : !pp_ndstb && pp_nastb), "R4 strobe select",
        {pp_nastb, pp_ndstb}, addr ? 2'b01 : 2'b10);
    chk(pp_nwrite == 0 && pp_doe == 1, "R4 write dir", {pp_nwrite, pp_doe}, 2'b01);
    chk(pp_dout == d, "R4 dout", pp_dout, d);
    repeat (20) @(negedge clk);
    chk((!pp_ndstb || !pp_nastb) && !hst_ready, "R5 strobe held", {pp_ndstb, pp_nastb, hst_ready}, 0);
    finish_cycle("R5 release");
    chk(sts_timeout == 0, "R7 no timeout", sts_timeout, 0);
  endtask

  task automatic t_read(input bit addr, input logic [DW-1:0] din);
    bit seen;
    pp_din = din;
    request(0, addr, 8'h00);
    wait_strobe(seen);
    chk(seen && pp_nwrite == 1 && pp_doe == 0, "R6 read dir", {seen, pp_nwrite, pp_doe}, 3'b110);
    finish_cycle("R6 release");
    chk(hst_rdata == din, "R6 rdata", hst_rdata, din);
  endtask

  task automatic t_precond();
    logic nw0;
    bit ok = 1, seen;
    pp_nwait = 1;
    repeat (3) @(negedge clk);
    nw0 = pp_nwrite;
    request(0, 0, 8'h00);
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (!pp_ndstb || !pp_nastb || pp_nwrite != nw0) ok = 0;
    end
    chk(ok, "R3 no change while nwait high", ok, 1);
    pp_nwait = 0;
    wait_strobe(seen);
    chk(seen, "R3 strobe after nwait low", seen, 1);
    finish_cycle("R3 release");
  endtask

  task automatic t_timeout();
    int lowc = 0;
    bit rdy = 0;
    pp_nwait = 0;
    request(0, 1, 8'h00);
    lowc = 1;
    for (int i = 0; i < TO + 10 && !rdy; i++) begin
      if (hst_ready) rdy = 1; else begin lowc++; @(negedge clk); end
    end
    lowc--;
    chk(lowc == TO, "R7 abort cycle count", lowc, TO);
    chk(sts_timeout && pp_ndstb && pp_nastb, "R7 flag and strobes", {sts_timeout, pp_ndstb, pp_nastb}, 3'b111);
    repeat (5) @(negedge clk);
    chk(sts_timeout == 1, "R8 sticky", sts_timeout, 1);
    sts_clr = 1; @(negedge clk); sts_clr = 0;
    chk(sts_timeout == 0, "R8 cleared", sts_timeout, 0);
  endtask

  task automatic t_override();
    bit seen;
    ctl_strobe_ovr = 1;
    request(0, 0, 8'h00);
    ctl_strobe_ovr = 0;
    wait_strobe(seen);
    chk(seen && pp_nwrite == 0 && pp_doe == 1, "R9 override on read", {seen, pp_nwrite, pp_doe}, 3'b101);
    finish_cycle("R9 release");
  endtask

  task automatic t_pcd(input logic [DW-1:0] prev);
    bit seen;
    ctl_dir_in = 1;
    pp_din = 8'h3C;
    request(1, 0, 8'h5A);
    wait_strobe(seen);
    chk(seen && pp_nwrite == 1 && pp_doe == 0, "R10 write becomes read", {seen, pp_nwrite, pp_doe}, 3'b110);
    chk(pp_dout == prev, "R10 dout unchanged", pp_dout, prev);
    finish_cycle("R10 release");
    chk(hst_rdata == 8'h3C, "R10 rdata", hst_rdata, 8'h3C);
    chk(sts_timeout == 0, "R10 no error", sts_timeout, 0);
    ctl_dir_in = 0;
  endtask

  task automatic t_hold();
    bit ok = 1, seen;
    request(1, 0, 8'h96);
    wait_strobe(seen);
    pp_nwait = 1;
    while (!hst_ready) @(negedge clk);
    request(0, 0, 8'h00);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (pp_nwrite != 0 || pp_doe != 1 || pp_dout != 8'h96) ok = 0;
    end
    chk(ok, "R11 hold until nwait low", ok, 1);
    pp_nwait = 0;
    wait_strobe(seen);
    chk(seen && pp_nwrite == 1, "R11 change after nwait low", pp_nwrite, 1);
    finish_cycle("R11 release");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(hst_ready && pp_nwrite && pp_ndstb && pp_nastb && !pp_doe && !sts_timeout,
        "R1 reset state", {hst_ready, pp_nwrite, pp_ndstb, pp_nastb, pp_doe, sts_timeout}, 6'b111100);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_write(0, 8'hA5);
    t_write(1, 8'hC3);
    t_read(0, 8'h71);
    t_read(1, 8'hE8);
    t_precond();
    t_timeout();
    t_override();
    t_pcd(8'hC3);
    t_hold();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule